// File: doc/BRIEF.md
# Predicated element issue compactor

This block drives the element loop of one vectorised operation onto a small bank of parallel ALU lanes. A start pulse captures the vector length, a predicate bit mask (one bit per element, so the longest vector equals the mask width), a mode flag and a base register index. On every following cycle the block presents up to `LANES` element slots. Each slot carries a valid bit, the element index, the destination register number and a zero-write flag. When the last group goes out, the block raises `done`.

In skip mode, elements whose predicate bit is clear are removed from the stream. The surviving elements are packed into consecutive lanes from lane 0, so the number of issue cycles follows the count of set predicate bits and not the vector length. As an example, with four lanes an 8-element operation with 6 active elements issues 4 slots and then 2. With one lane the same operation takes 6 cycles. In zeroing mode, every element below the vector length is issued in ascending order. Inactive elements are marked as zero-writes and share the lane slots with the active ones.

Top module: `predicated_issue_compactor`

## Requirements
- R1: A start while the block is idle captures vector length, mask, mode and base. Input changes after that cycle have no effect on the operation. A start while `busy` is high is ignored.
- R2: Within a cycle, the valid lanes are a contiguous group starting at lane 0, and their element indices rise with the lane number. Across cycles, elements are issued in ascending index order.
- R3: In skip mode (`zero_mode`=0), exactly the elements with index below the vector length and predicate bit set are issued, each once, and `lane_zero` stays 0. Predicate bits at or above the vector length are ignored.
- R4: The operation keeps `busy` high for max(1, ceil(G/LANES)) cycles, where G is the number of issued elements. Every issue cycle except the last fills all lanes.
- R5: In zeroing mode (`zero_mode`=1), every element below the vector length is issued. `lane_zero` is 1 exactly for the elements whose predicate bit is 0.
- R6: Each valid lane carries its element index in `lane_elem`. `lane_reg` holds (base + element index) modulo 2^REG_W. Lane k occupies bits [k*W +: W] of each packed bus.
- R7: `busy` rises the cycle after an accepted start, and `done` is high during the last busy cycle only. If nothing is to be issued (length 0, or no set bit in skip mode), the block is busy for one cycle with `done` high and no lane valid. No lane is valid while idle.
- R8: While `rst_n` is low at a clock edge, the block returns to idle, with `busy`, `done` and all `lane_valid` bits at 0.
- R9: A vector length above XLEN is treated as XLEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| vec_len | input | LEN_W | Number of elements, clamped to XLEN |
| pred_mask | input | XLEN | Predicate, bit i enables element i |
| zero_mode | input | 1 | 1: zero inactive elements, 0: skip them |
| base_reg | input | REG_W | Register number of element 0 |
| lane_valid | output | LANES | Lane carries an element this cycle |
| lane_zero | output | LANES | Lane slot is a zero-write for an inactive element |
| lane_elem | output | LANES*IDX_W | Element index per lane |
| lane_reg | output | LANES*REG_W | Destination register number per lane |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Last cycle of the operation |

## Verification
A corrupted pending-element mask shows up at the lanes in the same cycle: an element is repeated or missing, or the indices are out of order. It also shows up as `done` arriving too early or too late compared with the count of set predicate bits. A wrong captured base or mode bit is visible on the first issue cycle as a shifted register number or a wrong zero flag. A start accepted while busy changes the lane stream from the next cycle onward. A bench model built from queues, run with a one-lane and a four-lane configuration, compares every lane field on every clock, so each of these faults is reported within one cycle of appearing.

// File: rtl/pec_pkg.sv
// Shared definitions for the predicated element issue compactor.
// Assumes nothing beyond IEEE 1800-2017 packages.
package pec_pkg;

    // Handling of elements whose predicate bit is clear.
    typedef enum logic {
        PEC_SKIP = 1'b0,
        PEC_ZERO = 1'b1
    } pec_mode_e;

endpackage

// File: rtl/pec_lane_pick.sv
// Picks the lowest LANES set bits of a pending-element mask, lowest first,
// and reports the mask left over once they are removed.
// Assumes XLEN >= 2. Purely combinational; the chain is LANES stages deep.
module pec_lane_pick #(
    parameter int XLEN  = 32,
    parameter int LANES = 4,
    parameter int IDX_W = $clog2(XLEN)
) (
    input  logic [XLEN-1:0]        pend,
    output logic [LANES-1:0]       pick_valid,
    output logic [LANES*IDX_W-1:0] pick_idx,
    output logic [XLEN-1:0]        rest
);

    // One-hot to binary index.
    function automatic logic [IDX_W-1:0] onehot_to_idx(input logic [XLEN-1:0] oh);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = 0; i < XLEN; i++) begin
            if (oh[i]) r = r | IDX_W'(i);
        end
        return r;
    endfunction

    logic [XLEN-1:0] stage [LANES+1];

    assign stage[0] = pend;

    for (genvar l = 0; l < LANES; l++) begin : g_stage
        logic [XLEN-1:0] low_oh;

        // Isolate the lowest pending element for this lane.
        always_comb low_oh = stage[l] & (~stage[l] + XLEN'(1));

        assign pick_valid[l]              = |stage[l];
        assign pick_idx[l*IDX_W +: IDX_W] = onehot_to_idx(low_oh);
        assign stage[l+1]                 = stage[l] & ~low_oh;
    end

    assign rest = stage[LANES];

endmodule

// File: rtl/pec_lane_map.sv
// Turns picked element indices into lane outputs: destination register
// (base plus index, wrapping at 2^REG_W) and a zero-write flag for
// predicate-off elements in zeroing mode.
// Assumes the predicate and base are held stable for the whole operation.
module pec_lane_map
    import pec_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int LANES = 4,
    parameter int IDX_W = $clog2(XLEN),
    parameter int REG_W = 6
) (
    input  logic [LANES-1:0]       pick_valid,
    input  logic [LANES*IDX_W-1:0] pick_idx,
    input  logic [XLEN-1:0]        pred,
    input  logic [REG_W-1:0]       base,
    input  pec_mode_e              mode,
    output logic [LANES-1:0]       lane_valid,
    output logic [LANES-1:0]       lane_zero,
    output logic [LANES*IDX_W-1:0] lane_elem,
    output logic [LANES*REG_W-1:0] lane_reg
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [IDX_W-1:0] idx;

        assign idx = pick_idx[l*IDX_W +: IDX_W];

        // Per-lane field mapping.
        always_comb begin
            lane_valid[l]              = pick_valid[l];
            lane_zero[l]               = pick_valid[l] && (mode == PEC_ZERO) && !pred[idx];
            lane_elem[l*IDX_W +: IDX_W] = idx;
            lane_reg[l*REG_W +: REG_W] = base + REG_W'(idx);
        end
    end

endmodule

// File: rtl/predicated_issue_compactor.sv
// Issues the elements of one predicated vector operation to LANES ALU lanes.
// Active elements are packed into consecutive lanes. In zeroing mode, inactive
// elements are issued as zero-writes in ascending order.
// Assumes XLEN >= 2 and LANES >= 1. Outputs are combinational from state.
module predicated_issue_compactor
    import pec_pkg::*;
#(
    parameter  int XLEN  = 32,
    parameter  int LANES = 4,
    parameter  int REG_W = 6,
    localparam int LEN_W = $clog2(XLEN + 1),
    localparam int IDX_W = $clog2(XLEN)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [LEN_W-1:0]       vec_len,
    input  logic [XLEN-1:0]        pred_mask,
    input  logic                   zero_mode,
    input  logic [REG_W-1:0]       base_reg,
    output logic [LANES-1:0]       lane_valid,
    output logic [LANES-1:0]       lane_zero,
    output logic [LANES*IDX_W-1:0] lane_elem,
    output logic [LANES*REG_W-1:0] lane_reg,
    output logic                   busy,
    output logic                   done
);

    logic             busy_q;
    logic [XLEN-1:0]  pend_q;
    logic [XLEN-1:0]  pred_q;
    logic [REG_W-1:0] base_q;
    pec_mode_e        mode_q;

    logic [XLEN-1:0]  len_mask;
    logic [XLEN-1:0]  work_mask;
    logic [LANES-1:0] pick_valid;
    logic [LANES*IDX_W-1:0] pick_idx;
    logic [XLEN-1:0]  rest;

    // Elements below the (clamped) vector length.
    always_comb begin
        for (int i = 0; i < XLEN; i++) begin
            len_mask[i] = (LEN_W'(i) < vec_len);
        end
    end

    // Elements that will be issued: all in zeroing mode, active ones otherwise.
    always_comb work_mask = zero_mode ? len_mask : (len_mask & pred_mask);

    pec_lane_pick #(
        .XLEN  (XLEN),
        .LANES (LANES),
        .IDX_W (IDX_W)
    ) u_pick (
        .pend       (busy_q ? pend_q : '0),
        .pick_valid (pick_valid),
        .pick_idx   (pick_idx),
        .rest       (rest)
    );

    pec_lane_map #(
        .XLEN  (XLEN),
        .LANES (LANES),
        .IDX_W (IDX_W),
        .REG_W (REG_W)
    ) u_map (
        .pick_valid (pick_valid),
        .pick_idx   (pick_idx),
        .pred       (pred_q),
        .base       (base_q),
        .mode       (mode_q),
        .lane_valid (lane_valid),
        .lane_zero  (lane_zero),
        .lane_elem  (lane_elem),
        .lane_reg   (lane_reg)
    );

    assign busy = busy_q;
    assign done = busy_q && (rest == '0);

    // Operation state: capture on idle start, retire picked elements while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            pend_q <= '0;
            pred_q <= '0;
            base_q <= '0;
            mode_q <= PEC_SKIP;
        end else if (busy_q) begin
            pend_q <= rest;
            if (done) busy_q <= 1'b0;
        end else if (start) begin
            busy_q <= 1'b1;
            pend_q <= work_mask;
            pred_q <= pred_mask;
            base_q <= base_reg;
            mode_q <= zero_mode ? PEC_ZERO : PEC_SKIP;
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !busy && lane_valid == '0); // R8

    AST_LANES_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
        ((lane_valid + LANES'(1)) & lane_valid) == '0); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (lane_valid == '0 && !done)); // R7

    AST_DONE_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R7

    AST_CAPTURE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start |=> $stable(base_q) && $stable(mode_q) && $stable(pred_q)); // R1

    AST_SKIP_NO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mode_q == PEC_SKIP) |-> lane_zero == '0); // R3

    for (genvar l = 1; l < LANES; l++) begin : g_order_chk
        AST_LANE_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
            lane_valid[l] |-> lane_elem[l*IDX_W +: IDX_W] > lane_elem[(l-1)*IDX_W +: IDX_W]); // R2
    end

endmodule

// File: tb/predicated_issue_compactor_tb.sv
// Bench: a four-lane and a one-lane instance take the same stimulus. A
// queue-based reference model per instance is compared on every clock.
module predicated_issue_compactor_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [5:0]  vec_len = '0;
    logic [31:0] pred_mask = '0;
    logic        zero_mode = 1'b0;
    logic [5:0]  base_reg = '0;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #2 clk = ~clk;   // 250 MHz

    // Record one check.
    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    for (genvar c = 0; c < 2; c++) begin : g_cfg
        localparam int L = (c == 0) ? 4 : 1;

        logic [L-1:0]   lv, lz;
        logic [L*5-1:0] le;
        logic [L*6-1:0] lr;
        logic           bsy, dn;

        predicated_issue_compactor #(.XLEN(32), .LANES(L), .REG_W(6)) u_dut (
            .clk (clk), .rst_n (rst_n), .start (start), .vec_len (vec_len),
            .pred_mask (pred_mask), .zero_mode (zero_mode), .base_reg (base_reg),
            .lane_valid (lv), .lane_zero (lz), .lane_elem (le), .lane_reg (lr),
            .busy (bsy), .done (dn)
        );

        int qi[$];
        int qz[$];
        int base_m, exp_cyc, cyc, n, shown;
        bit busy_m, done_m;

        // Reference model state update.
        always @(posedge clk) begin
            if (!rst_n) begin
                busy_m = 0; qi.delete(); qz.delete();
            end else if (busy_m) begin
                if (qi.size() <= L) begin
                    qi.delete(); qz.delete(); busy_m = 0;
                end else begin
                    for (int k = 0; k < L; k++) begin
                        void'(qi.pop_front()); void'(qz.pop_front());
                    end
                end
            end else if (start) begin
                n = (vec_len > 32) ? 32 : int'(vec_len);      // R9 clamp
                for (int e = 0; e < n; e++) begin
                    if (zero_mode || pred_mask[e]) begin
                        qi.push_back(e);
                        qz.push_back((zero_mode && !pred_mask[e]) ? 1 : 0);
                    end
                end
                base_m  = int'(base_reg);
                busy_m  = 1;
                exp_cyc = (qi.size() == 0) ? 1 : (qi.size() + L - 1) / L;
                cyc     = 0;
            end
        end

        // Per-cycle comparison away from the active edge.
        always @(negedge clk) begin
            if (rst_n && !finished) begin
                shown  = busy_m ? ((qi.size() < L) ? qi.size() : L) : 0;
                done_m = busy_m && (qi.size() <= L);
                chk(bsy == busy_m, $sformatf("R7 cfg%0d busy", c), bsy, busy_m);
                chk(dn == done_m, $sformatf("R7 cfg%0d done", c), dn, done_m);
                for (int k = 0; k < L; k++) begin
                    chk(lv[k] == (k < shown), $sformatf("R2/R3/R5 cfg%0d lane%0d valid", c, k),
                        lv[k], k < shown);
                    if (k < shown) begin
                        chk(int'(le[k*5 +: 5]) == qi[k],
                            $sformatf("R1/R2/R6 cfg%0d lane%0d elem", c, k), le[k*5 +: 5], qi[k]);
                        chk(int'(lr[k*6 +: 6]) == ((base_m + qi[k]) & 63),
                            $sformatf("R6 cfg%0d lane%0d reg", c, k), lr[k*6 +: 6],
                            (base_m + qi[k]) & 63);
                        chk(int'(lz[k]) == qz[k],
                            $sformatf("R3/R5 cfg%0d lane%0d zero", c, k), lz[k], qz[k]);
                    end
                end
                if (busy_m) begin
                    cyc++;
                    if (done_m) chk(cyc == exp_cyc, $sformatf("R4 cfg%0d issue cycles", c), cyc, exp_cyc);
                end
            end
        end
    end

    // Run one operation; scramble the inputs afterwards, optionally re-pulse start.
    task automatic op(input int len, input logic [31:0] m, input bit z, input int b, input bit poke);
        @(posedge clk); #1;
        start = 1; vec_len = 6'(len); pred_mask = m; zero_mode = z; base_reg = 6'(b);
        @(posedge clk); #1;
        start = 0; vec_len = 6'd63; pred_mask = ~m; zero_mode = ~z; base_reg = 6'(b + 17);
        if (poke) begin
            @(posedge clk); #1; start = 1;          // R1: must be ignored
            @(posedge clk); #1; start = 0;
        end
        while (g_cfg[0].bsy || g_cfg[1].bsy) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(g_cfg[0].bsy == 0 && g_cfg[0].dn == 0, "R8 reset busy/done", g_cfg[0].bsy, 0);
        chk(g_cfg[0].lv == '0 && g_cfg[1].lv == '0, "R8 reset lanes", g_cfg[0].lv, 0);
        @(posedge clk); #1; rst_n = 1;

        op(8, 32'h0000_00BB, 0, 3, 0);     // R4: 6 active -> 4+2 / 6 cycles
        op(8, 32'h0000_00BB, 1, 3, 0);     // R5: zeroing, 8 slots
        op(0, 32'hFFFF_FFFF, 0, 0, 0);     // R7: empty length
        op(5, 32'h0000_0000, 0, 9, 0);     // R7: no active element
        op(5, 32'h0000_0000, 1, 9, 0);     // R5: all zero-writes
        op(4, 32'hFFFF_FFF0, 0, 1, 0);     // R3: bits above length ignored
        op(40, 32'hFFFF_FFFF, 0, 5, 0);    // R9: clamp to 32
        op(10, 32'h0000_03FF, 0, 60, 0);   // R6: register wrap
        op(8, 32'h0000_00BB, 0, 2, 1);     // R1: start while busy
        op(12, 32'h0000_0A5A, 1, 7, 1);    // R1 in zeroing mode

        lfsr = 32'h1234_5678;
        for (int r = 0; r < 24; r++) begin
            for (int s = 0; s < 7; s++) lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            op(int'(lfsr[5:0]), lfsr ^ {lfsr[15:0], lfsr[31:16]}, lfsr[7], int'(lfsr[13:8]), lfsr[9]);
        end

        repeat (3) @(negedge clk);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule